// File: doc/BRIEF.md
# Switchable-Depth Serial Receive Buffer

This block holds the characters a serial receiver has assembled until software reads them. Each entry is 12 bits wide. The low 8 bits carry the data byte and the upper 4 bits carry the error flags. The block has two modes, picked at run time by a FIFO-enable control bit:

- With the bit set, it is a 16-entry circular queue.
- With the bit clear, it is a single holding register.

Writing the control bit with a value different from the current one empties the buffer.

Characters arrive on a valid/ready stream. A beat transfers on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only when all of these hold:

- the stored count is below the effective depth;
- no line-break pulse is present;
- no mode-changing control write is present.

Back-pressure is the only flow control. The sender must hold `in_valid` and `in_data` until the transfer happens. A line-break pulse on `in_break` stores its own marker entry and takes precedence over a data beat in the same cycle.

The read side is a plain strobe, as issued by a data-register read. `head_entry` always shows the entry at the read pointer. `rd_pop` consumes that entry and copies its upper 4 bits into a status register, which `stat_clr` zeroes. The block also provides a flag byte and a receive interrupt request with a trigger level of one entry.

Top module: `rxq_buffer`

## Requirements
- R1: After reset the buffer is empty, FIFO mode is off, `flag_reg` reads 0x90, `rx_irq` is 0, `rx_status` is 0 and `in_ready` is 1.
- R2: The effective depth is 16 when FIFO mode is on and 1 when it is off. `in_ready` stays high exactly while the count is below that depth.
- R3: Entries leave in the order they were stored. The write slot is (read pointer + count) modulo the effective depth, and the read pointer wraps modulo the effective depth.
- R4: The `flag_reg` layout is fixed:
  - bit 4 is receive-empty (count is 0);
  - bit 6 is receive-full (count equals the effective depth);
  - bit 7 (transmit-empty) reads 1;
  - bit 5 (transmit-full) and all other bits read 0.
- R5: A pop with count 0 leaves the count at 0. It still latches the status bits of the entry at the read pointer.
- R6: Each pop copies bits 11:8 of `head_entry` into `rx_status`. `stat_clr` zeroes `rx_status`. A pop in the same cycle as `stat_clr` wins.
- R7: A pulse on `in_break` stores the entry 0x400, which is data 0 with error bit 10 set. While `in_break` is high, `in_ready` is low and a data beat is not taken.
- R8: `rx_irq` rises when a store brings the count to 1. It falls when a pop leaves the count at 0. When a pop and a store share a cycle, the pop is applied first and the store second.
- R9: A `cfg_we` whose `cfg_fifo_en` differs from the current mode does three things: it zeroes the count and the read pointer, it ignores any store or pop in that cycle, and it leaves `rx_irq` unchanged. A `cfg_we` with the same value has no effect on stored state.
- R10: A beat offered while the buffer is full is not accepted, and the stored entries are unchanged.
- R11: A store and a pop in the same cycle both take effect. With a nonzero count, the count is unchanged and the read pointer advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Incoming character is valid |
| in_ready | output | 1 | Buffer can accept a character this cycle |
| in_data | input | 12 | Incoming entry: error flags 11:8, data 7:0 |
| in_break | input | 1 | Line-break pulse; stores entry 0x400 |
| rd_pop | input | 1 | Data-register read strobe; consumes the head entry |
| head_entry | output | 12 | Entry at the read pointer |
| stat_clr | input | 1 | Write strobe that zeroes the receive status |
| rx_status | output | 4 | Error flags of the last popped entry |
| cfg_we | input | 1 | Line-control write strobe |
| cfg_fifo_en | input | 1 | FIFO-enable field of the line-control write |
| flag_reg | output | 8 | Flag byte: bit 4 rx empty, bit 5 tx full, bit 6 rx full, bit 7 tx empty |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The case that needs care is a store and a pop landing on the same edge. The bench provokes it twice from the vector table:

- With two entries held: the count must stay at two, the head must move to the next entry, and the interrupt must stay high.
- With the buffer empty: the pop finds nothing, so it only latches the stale head's status and drops the interrupt. The store then raises the interrupt again, and the new character becomes the head.

A third collision, a mode toggle coinciding with a store, is judged by the buffer reading empty afterwards while the interrupt is still held.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W  = 8;
  localparam int ERR_W   = 4;
  localparam int ENTRY_W = DATA_W + ERR_W;
  localparam int BRK_BIT = DATA_W + 2;

  typedef struct packed {
    logic [ERR_W-1:0]  err;
    logic [DATA_W-1:0] data;
  } rxq_entry_t;

  localparam logic [ENTRY_W-1:0] BREAK_ENTRY = ENTRY_W'(1) << BRK_BIT;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             flush,
  input  logic             push_fire,
  input  logic             pop_fire,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] depth_eff,
  output logic [PTR_W-1:0] rptr,
  output logic [PTR_W-1:0] wslot
);
  logic [PTR_W-1:0] mask;
  logic             pop_take;

  always_comb begin
    mask      = fifo_en ? PTR_W'(DEPTH - 1) : '0;
    depth_eff = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
    pop_take  = pop_fire && (count != '0);
    wslot     = (rptr + count[PTR_W-1:0]) & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      rptr  <= '0;
    end else if (flush) begin
      count <= '0;
      rptr  <= '0;
    end else begin
      count <= count - CNT_W'(pop_take) + CNT_W'(push_fire);
      if (pop_take) rptr <= (rptr + PTR_W'(1)) & mask;
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= depth_eff);
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |-> count < depth_eff);
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0) && (rptr == '0));
  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !push_fire && !flush && count == '0) |=> count == '0);
  assert_both_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && push_fire && !flush && count != '0) |=> count == $past(count));
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 12,
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [PTR_W-1:0]   wslot,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic [PTR_W-1:0]   rptr,
  output logic [ENTRY_W-1:0] rdata
);
  logic [ENTRY_W-1:0] slots [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slots[g] <= '0;
      else if (we && wslot == PTR_W'(g))       slots[g] <= wdata;
    end
  end

  assign rdata = slots[rptr];
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
  parameter int CNT_W    = 5,
  parameter int TRIG_LVL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push_fire,
  input  logic             pop_fire,
  input  logic [CNT_W-1:0] count,
  output logic             irq
);
  logic [CNT_W-1:0] after_pop;
  logic             irq_next;

  always_comb begin
    after_pop = (pop_fire && count != '0) ? count - CNT_W'(1) : count;
    irq_next  = irq;
    if (pop_fire && after_pop == CNT_W'(TRIG_LVL - 1))               irq_next = 1'b0;
    if (push_fire && (after_pop + CNT_W'(1)) == CNT_W'(TRIG_LVL))    irq_next = 1'b1;
    if (flush)                                                       irq_next = irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_next;
  end

  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> irq == $past(irq));
  assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && pop_fire && !push_fire && count <= CNT_W'(TRIG_LVL)) |=> !irq);
endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer #(
  parameter int DEPTH    = 16,
  parameter int TRIG_LVL = 1,
  localparam int ENTRY_W = rxq_pkg::ENTRY_W,
  localparam int ERR_W   = rxq_pkg::ERR_W,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = PTR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ENTRY_W-1:0] in_data,
  input  logic               in_break,
  input  logic               rd_pop,
  output logic [ENTRY_W-1:0] head_entry,
  input  logic               stat_clr,
  output logic [ERR_W-1:0]   rx_status,
  input  logic               cfg_we,
  input  logic               cfg_fifo_en,
  output logic [7:0]         flag_reg,
  output logic               rx_irq
);
  import rxq_pkg::*;

  logic             fifo_en, flush, room, push_fire, pop_fire;
  logic [CNT_W-1:0] count, depth_eff;
  logic [PTR_W-1:0] rptr, wslot;
  rxq_entry_t       wentry, head;

  always_comb begin
    flush     = cfg_we && (cfg_fifo_en != fifo_en);
    room      = (count < depth_eff) && !flush;
    in_ready  = room && !in_break;
    push_fire = room && (in_break || in_valid);
    pop_fire  = rd_pop && !flush;
    wentry    = in_break ? rxq_entry_t'(BREAK_ENTRY) : rxq_entry_t'(in_data);
    flag_reg  = {1'b1, count == depth_eff, 1'b0, count == '0, 4'b0000};
  end

  assign head_entry = head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en   <= 1'b0;
      rx_status <= '0;
    end else begin
      if (cfg_we)        fifo_en   <= cfg_fifo_en;
      if (pop_fire)      rx_status <= head.err;
      else if (stat_clr) rx_status <= '0;
    end
  end

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush(flush),
    .push_fire(push_fire), .pop_fire(pop_fire), .count(count),
    .depth_eff(depth_eff), .rptr(rptr), .wslot(wslot)
  );

  rxq_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(push_fire), .wslot(wslot),
    .wdata(wentry), .rptr(rptr), .rdata(head)
  );

  rxq_irq #(.CNT_W(CNT_W), .TRIG_LVL(TRIG_LVL)) u_irq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push_fire(push_fire),
    .pop_fire(pop_fire), .count(count), .irq(rx_irq)
  );

  assert_break_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_break |-> !in_ready);
  assert_pop_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> rx_status == $past(head_entry[ENTRY_W-1 -: ERR_W]));
  assert_stat_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !pop_fire) |=> rx_status == '0);
  assert_flag_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_reg[4] && flag_reg[6]));
endmodule

// File: tb/rxq_buffer_tb.sv
module rxq_buffer_tb;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_break = 0, rd_pop = 0, stat_clr = 0, cfg_we = 0, cfg_fifo_en = 0;
  logic [11:0] in_data = '0;
  logic in_ready, rx_irq;
  logic [11:0] head_entry;
  logic [3:0] rx_status;
  logic [7:0] flag_reg;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rxq_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_break(in_break), .rd_pop(rd_pop),
    .head_entry(head_entry), .stat_clr(stat_clr), .rx_status(rx_status),
    .cfg_we(cfg_we), .cfg_fifo_en(cfg_fifo_en), .flag_reg(flag_reg), .rx_irq(rx_irq)
  );

  typedef struct packed {
    logic we; logic en; logic push; logic brk; logic pop; logic [11:0] d;
    logic [7:0] fl; logic irq; logic rdy; logic [11:0] head; logic [3:0] st;
  } vec_t;

  // Order of each row: cfg write, enable value, push, break, pop, data | flags, irq, ready, head, status
  localparam vec_t VEC [0:17] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0,12'h0A5, 8'hC0,1'b1,1'b0,12'h0A5,4'h0}, // R2 depth 1 full
    '{1'b0,1'b0,1'b1,1'b0,1'b0,12'h123, 8'hC0,1'b1,1'b0,12'h0A5,4'h0}, // R10 dropped
    '{1'b0,1'b0,1'b0,1'b0,1'b1,12'h000, 8'h90,1'b0,1'b1,12'h0A5,4'h0}, // R8 drop
    '{1'b0,1'b0,1'b1,1'b0,1'b0,12'h3C1, 8'hC0,1'b1,1'b0,12'h3C1,4'h0},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,12'h000, 8'h90,1'b0,1'b1,12'h3C1,4'h3}, // R6 latch
    '{1'b0,1'b0,1'b0,1'b0,1'b1,12'h000, 8'h90,1'b0,1'b1,12'h3C1,4'h3}, // R5 empty pop
    '{1'b0,1'b0,1'b0,1'b1,1'b0,12'h000, 8'hC0,1'b1,1'b0,12'h400,4'h3}, // R7 break
    '{1'b0,1'b0,1'b0,1'b0,1'b1,12'h000, 8'h90,1'b0,1'b1,12'h400,4'h4}, // R7 status
    '{1'b1,1'b1,1'b0,1'b0,1'b0,12'h000, 8'h90,1'b0,1'b1,12'h400,4'h4}, // R9 toggle on
    '{1'b0,1'b0,1'b1,1'b0,1'b0,12'h011, 8'h80,1'b1,1'b1,12'h011,4'h4}, // R4 R8
    '{1'b0,1'b0,1'b1,1'b0,1'b0,12'h822, 8'h80,1'b1,1'b1,12'h011,4'h4}, // R3
    '{1'b0,1'b0,1'b1,1'b0,1'b1,12'h233, 8'h80,1'b1,1'b1,12'h822,4'h0}, // R11 both
    '{1'b0,1'b0,1'b0,1'b0,1'b1,12'h000, 8'h80,1'b1,1'b1,12'h233,4'h8}, // R3 order
    '{1'b0,1'b0,1'b0,1'b0,1'b1,12'h000, 8'h90,1'b0,1'b1,12'h000,4'h2},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,12'h144, 8'h80,1'b1,1'b1,12'h144,4'h0}, // R8 R11 empty both
    '{1'b1,1'b1,1'b0,1'b0,1'b0,12'h000, 8'h80,1'b1,1'b1,12'h144,4'h0}, // R9 same value
    '{1'b1,1'b0,1'b1,1'b0,1'b0,12'h0FF, 8'h90,1'b1,1'b1,12'h011,4'h0}, // R9 toggle off
    '{1'b0,1'b0,1'b0,1'b0,1'b1,12'h000, 8'h90,1'b0,1'b1,12'h011,4'h0}  // R8 clear
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, en, pv, brk, pop, clr, input logic [11:0] d);
    @(negedge clk);
    cfg_we = we; cfg_fifo_en = en; in_valid = pv; in_break = brk;
    rd_pop = pop; stat_clr = clr; in_data = d;
    @(posedge clk); #1;
    cfg_we = 0; in_valid = 0; in_break = 0; rd_pop = 0; stat_clr = 0;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    #1;
    check("R1 flags", flag_reg, 8'h90);
    check("R1 irq", rx_irq, 0);
    check("R1 ready", in_ready, 1);
    check("R1 status", rx_status, 0);

    foreach (VEC[i]) begin
      step(VEC[i].we, VEC[i].en, VEC[i].push, VEC[i].brk, VEC[i].pop, 1'b0, VEC[i].d);
      check($sformatf("R4 vec%0d flags", i), flag_reg, VEC[i].fl);
      check($sformatf("R8 vec%0d irq", i), rx_irq, VEC[i].irq);
      check($sformatf("R2 vec%0d ready", i), in_ready, VEC[i].rdy);
      check($sformatf("R3 vec%0d head", i), head_entry, VEC[i].head);
      check($sformatf("R6 vec%0d status", i), rx_status, VEC[i].st);
    end

    // Fresh start: wrap-around fill of 16 entries in FIFO mode
    do_reset();
    step(1, 1, 0, 0, 0, 0, 12'h0);
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, 0, 12'(8'hA0 + i));
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, 0, 12'h0);
    for (int i = 0; i < 16; i++) step(0, 0, 1, 0, 0, 0, {4'(i), 8'(8'h30 + i)});
    check("R4 full flags", flag_reg, 8'hC0);
    check("R2 ready low at 16", in_ready, 0);
    step(0, 0, 1, 0, 0, 0, 12'hFFF);
    check("R10 head unchanged", head_entry, 12'h030);
    for (int i = 0; i < 16; i++) begin
      check("R3 wrap order", head_entry, {4'(i), 8'(8'h30 + i)});
      step(0, 0, 0, 0, 1, 0, 12'h0);
      check("R6 status per pop", rx_status, i);
    end
    check("R4 empty after drain", flag_reg, 8'h90);
    check("R8 irq after drain", rx_irq, 0);

    step(0, 0, 0, 0, 0, 1, 12'h0);
    check("R6 clear", rx_status, 0);
    step(0, 0, 1, 0, 0, 0, 12'h5AB);
    step(0, 0, 0, 0, 1, 1, 12'h0);
    check("R6 pop beats clear", rx_status, 5);

    // Break and data together: only the break entry is stored
    @(negedge clk);
    in_break = 1; in_valid = 1; in_data = 12'h0EE;
    #1 check("R7 ready low during break", in_ready, 0);
    @(posedge clk); #1;
    in_break = 0; in_valid = 0; #1;
    check("R7 break entry", head_entry, 12'h400);
    check("R7 one entry", flag_reg, 8'h80);
    step(0, 0, 0, 0, 1, 0, 12'h0);
    check("R7 break status", rx_status, 4);
    check("R7 data beat not taken", flag_reg, 8'h90);

    finish_run();
  end
endmodule